// File: doc/BRIEF.md
# Snooping MSI Cache Coherence Controller

This block is the coherence engine that sits between a core and an atomically ordered broadcast bus. It holds a three-state coherence record (invalid, shared, modified) for each line of a small direct-mapped set, where a line is named by its index alone. On the core side it takes load, store and replace requests. Each request is either served at once, refused so the core retries, or turned into a bus transaction. In the last case a completion pulse follows when the data arrives.

On the bus side it places GetS, GetM and PutM requests and watches every ordered request on the bus, its own included. It tells its own requests apart by the requestor ID field. Every miss has two phases: the request first waits for its place in bus order, then the line waits for data. Snooped requests from other caches make this controller supply data to the requestor, to memory or to both. Only one bus transaction of this controller is in flight at any time.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid. `bus_req_valid`, `dat_out_valid` and `core_done` are low, and the first load of any line becomes a bus request instead of a hit.
- R2: A load (core op 0) to an invalid line is accepted without `core_hit` and raises a GetS (bus op 0) for that index. The line stalls the core until its own GetS has been snooped and a data message addressed to this controller's ID has arrived. `core_done` pulses in the cycle after that data, and later loads to the line hit.
- R3: A store (core op 1) to an invalid line raises a GetM (bus op 1). After its own GetM and the data, `core_done` pulses and later stores and loads to the line hit.
- R4: A store to a shared line raises a GetM. Loads to that line keep hitting while the upgrade waits for its bus slot and for its data, and stores stall. After the data, stores hit.
- R5: While an upgrade still waits for its own GetM, a GetM from another cache turns it into a plain miss. The line then stalls loads, supplies no data, and still completes to modified on its own GetM and data.
- R6: A modified line that snoops another cache's GetS sends data to the requestor and to memory and becomes shared. One that snoops another cache's GetM sends data to the requestor only and becomes invalid. The data message appears in the cycle after the snoop and carries the snooped requestor ID and index.
- R7: A shared line that snoops another cache's GetM becomes invalid without sending data.
- R8: Replace (core op 2) of a shared line invalidates it with no bus request. Replace of a modified line raises a PutM (bus op 2). Until its own PutM is snooped, loads and stores hit and replace stalls. Its own PutM sends data to memory only and leaves the line invalid.
- R9: A line waiting for its own PutM that snoops another cache's GetS sends data to requestor and memory; one that snoops another cache's GetM sends data to the requestor only. Either way the line stalls all core requests until its own PutM, which then sends no data and leaves the line invalid.
- R10: A request stalls (`core_req_ready` low) when its line is in a transient state other than the hits listed above, or when it needs the bus while any line is transient. It also stalls when a snoop or a data message for the same index is present in that cycle.
- R11: Snoops of any opcode for an invalid line produce no data message and leave the line invalid. Data messages addressed to another ID are ignored.
- R12: A bus request stays asserted with unchanged opcode and index until a cycle with `bus_req_grant` high, and it carries this controller's ID as source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_valid | input | 1 | Core request present |
| core_req_op | input | 2 | 0 load, 1 store, 2 replace |
| core_req_idx | input | IDX_W | Line index of the request |
| core_req_ready | output | 1 | Request accepted this cycle |
| core_hit | output | 1 | Accepted request served from the line this cycle |
| core_done | output | 1 | Pending miss completed (one cycle after its data) |
| bus_req_valid | output | 1 | Outgoing bus request pending |
| bus_req_op | output | 2 | 0 GetS, 1 GetM, 2 PutM |
| bus_req_src | output | ID_W | This controller's ID |
| bus_req_idx | output | IDX_W | Line index of the request |
| bus_req_grant | input | 1 | Bus has taken the pending request |
| snp_valid | input | 1 | Ordered bus request observed |
| snp_op | input | 2 | Opcode of the snooped request |
| snp_src | input | ID_W | Requestor ID of the snooped request |
| snp_idx | input | IDX_W | Line index of the snooped request |
| dat_in_valid | input | 1 | Data message present |
| dat_in_dst | input | ID_W | Destination ID of the data message |
| dat_in_idx | input | IDX_W | Line index of the data message |
| dat_out_valid | output | 1 | This controller sends data |
| dat_out_to_req | output | 1 | Data goes to the snooped requestor |
| dat_out_to_mem | output | 1 | Data goes to memory |
| dat_out_req_id | output | ID_W | Requestor ID the data answers |
| dat_out_idx | output | IDX_W | Line index of the data |

## Verification
Directed sequences drive each line through its own path: a cold load miss, a cold store miss, an upgrade from shared, the upgrade that loses a race to a foreign GetM, and evictions with and without a foreign snoop arriving between the PutM and its own appearance on the bus. Foreign GetS and GetM snoops are applied to modified, shared, evicting and invalid lines. The data-out flags show whether a request was told apart as own or foreign, and whether GetS was told apart from GetM. After each transition, a follow-up core load or store is used to read the new state through hit, stall or the opcode of a fresh bus request. Data sent to another ID and a delayed grant check the message filtering and the request hold.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [3:0] {
        ST_I, ST_S, ST_M,
        ST_ISAD, ST_ISD, ST_IMAD, ST_IMD, ST_SMAD, ST_SMD,
        ST_MIA, ST_IIA
    } line_st_t;

    typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_STORE = 2'd1, OP_REPL = 2'd2} core_op_t;
    typedef enum logic [1:0] {BUS_GETS = 2'd0, BUS_GETM = 2'd1, BUS_PUTM = 2'd2} bus_op_t;
    typedef enum logic [1:0] {ACT_STALL, ACT_HIT, ACT_BUS, ACT_QUIET} core_act_t;

    function automatic logic is_transient(line_st_t st);
        return !(st == ST_I || st == ST_S || st == ST_M);
    endfunction

    function automatic core_act_t classify(line_st_t st, core_op_t op);
        core_act_t a;
        a = ACT_STALL;
        case (st)
            ST_I: case (op)
                OP_LOAD, OP_STORE: a = ACT_BUS;
                OP_REPL:           a = ACT_QUIET;
                default:           a = ACT_STALL;
            endcase
            ST_S: case (op)
                OP_LOAD:  a = ACT_HIT;
                OP_STORE: a = ACT_BUS;
                OP_REPL:  a = ACT_QUIET;
                default:  a = ACT_STALL;
            endcase
            ST_M: case (op)
                OP_LOAD, OP_STORE: a = ACT_HIT;
                OP_REPL:           a = ACT_BUS;
                default:           a = ACT_STALL;
            endcase
            ST_SMAD, ST_SMD: a = (op == OP_LOAD) ? ACT_HIT : ACT_STALL;
            ST_MIA:          a = (op == OP_LOAD || op == OP_STORE) ? ACT_HIT : ACT_STALL;
            default:         a = ACT_STALL;
        endcase
        return a;
    endfunction

    function automatic bus_op_t bus_op_for(core_op_t op);
        case (op)
            OP_LOAD:  return BUS_GETS;
            OP_STORE: return BUS_GETM;
            default:  return BUS_PUTM;
        endcase
    endfunction

endpackage

// File: rtl/msi_line.sv
module msi_line
    import msi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     core_fire,
    input  core_op_t core_op,
    input  logic     snp_hit,
    input  bus_op_t  snp_op,
    input  logic     snp_own,
    input  logic     dat_hit,
    output line_st_t st,
    output logic     send_req,
    output logic     send_mem,
    output logic     done
);

    line_st_t nxt;

    always_comb begin
        nxt      = st;
        send_req = 1'b0;
        send_mem = 1'b0;
        done     = 1'b0;
        if (core_fire) begin
            case (st)
                ST_I: if (core_op == OP_LOAD) nxt = ST_ISAD;
                      else if (core_op == OP_STORE) nxt = ST_IMAD;
                ST_S: if (core_op == OP_STORE) nxt = ST_SMAD;
                      else if (core_op == OP_REPL) nxt = ST_I;
                ST_M: if (core_op == OP_REPL) nxt = ST_MIA;
                default: ;
            endcase
        end
        if (snp_hit) begin
            case (st)
                ST_ISAD: if (snp_own && snp_op == BUS_GETS) nxt = ST_ISD;
                ST_IMAD: if (snp_own && snp_op == BUS_GETM) nxt = ST_IMD;
                ST_SMAD: if (snp_op == BUS_GETM) nxt = snp_own ? ST_SMD : ST_IMAD;
                ST_S:    if (!snp_own && snp_op == BUS_GETM) nxt = ST_I;
                ST_M: if (!snp_own && snp_op == BUS_GETS) begin
                          send_req = 1'b1; send_mem = 1'b1; nxt = ST_S;
                      end else if (!snp_own && snp_op == BUS_GETM) begin
                          send_req = 1'b1; nxt = ST_I;
                      end
                ST_MIA: if (snp_own && snp_op == BUS_PUTM) begin
                            send_mem = 1'b1; nxt = ST_I;
                        end else if (!snp_own && snp_op == BUS_GETS) begin
                            send_req = 1'b1; send_mem = 1'b1; nxt = ST_IIA;
                        end else if (!snp_own && snp_op == BUS_GETM) begin
                            send_req = 1'b1; nxt = ST_IIA;
                        end
                ST_IIA: if (snp_own && snp_op == BUS_PUTM) nxt = ST_I;
                default: ;
            endcase
        end
        if (dat_hit) begin
            case (st)
                ST_ISD:         begin nxt = ST_S; done = 1'b1; end
                ST_IMD, ST_SMD: begin nxt = ST_M; done = 1'b1; end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_I;
        else     st <= nxt;
    end

endmodule

// File: rtl/msi_bus_req.sv
module msi_bus_req
    import msi_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  bus_op_t          op,
    input  logic [IDX_W-1:0] idx,
    input  logic             grant,
    output logic             valid,
    output bus_op_t          op_q,
    output logic [IDX_W-1:0] idx_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            op_q  <= BUS_GETS;
            idx_q <= '0;
        end else if (issue) begin
            valid <= 1'b1;
            op_q  <= op;
            idx_q <= idx;
        end else if (grant) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/msi_dat_out.sv
module msi_dat_out #(
    parameter int ID_W  = 2,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             to_req,
    input  logic             to_mem,
    input  logic [ID_W-1:0]  req_id,
    input  logic [IDX_W-1:0] idx,
    output logic             valid_q,
    output logic             to_req_q,
    output logic             to_mem_q,
    output logic [ID_W-1:0]  req_id_q,
    output logic [IDX_W-1:0] idx_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            to_req_q <= 1'b0;
            to_mem_q <= 1'b0;
            req_id_q <= '0;
            idx_q    <= '0;
        end else begin
            valid_q  <= to_req | to_mem;
            to_req_q <= to_req;
            to_mem_q <= to_mem;
            req_id_q <= req_id;
            idx_q    <= idx;
        end
    end

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int LINES = 4,
    parameter int ID_W  = 2,
    parameter int MY_ID = 1,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             core_req_valid,
    input  logic [1:0]       core_req_op,
    input  logic [IDX_W-1:0] core_req_idx,
    output logic             core_req_ready,
    output logic             core_hit,
    output logic             core_done,
    output logic             bus_req_valid,
    output logic [1:0]       bus_req_op,
    output logic [ID_W-1:0]  bus_req_src,
    output logic [IDX_W-1:0] bus_req_idx,
    input  logic             bus_req_grant,
    input  logic             snp_valid,
    input  logic [1:0]       snp_op,
    input  logic [ID_W-1:0]  snp_src,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic             dat_in_valid,
    input  logic [ID_W-1:0]  dat_in_dst,
    input  logic [IDX_W-1:0] dat_in_idx,
    output logic             dat_out_valid,
    output logic             dat_out_to_req,
    output logic             dat_out_to_mem,
    output logic [ID_W-1:0]  dat_out_req_id,
    output logic [IDX_W-1:0] dat_out_idx
);

    localparam logic [ID_W-1:0] SELF = ID_W'(MY_ID);

    line_st_t         st [LINES];
    logic [LINES-1:0] sreq_v, smem_v, done_v;
    core_op_t         cop;
    core_act_t        act;
    logic             busy, conflict, core_fire, snp_own, dat_mine;
    bus_op_t          req_op_q;

    assign cop      = core_op_t'(core_req_op);
    assign act      = classify(st[core_req_idx], cop);
    assign snp_own  = (snp_src == SELF);
    assign dat_mine = dat_in_valid && (dat_in_dst == SELF);

    always_comb begin
        busy = 1'b0;
        for (int k = 0; k < LINES; k++) busy |= is_transient(st[k]);
    end

    assign conflict = (snp_valid && snp_idx == core_req_idx) ||
                      (dat_in_valid && dat_in_idx == core_req_idx);

    assign core_req_ready = !conflict && (act != ACT_STALL) && !(act == ACT_BUS && busy);
    assign core_fire      = core_req_valid && core_req_ready;
    assign core_hit       = core_fire && (act == ACT_HIT);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        msi_line u_line (
            .clk      (clk),
            .rst      (rst),
            .core_fire(core_fire && core_req_idx == IDX_W'(g)),
            .core_op  (cop),
            .snp_hit  (snp_valid && snp_idx == IDX_W'(g)),
            .snp_op   (bus_op_t'(snp_op)),
            .snp_own  (snp_own),
            .dat_hit  (dat_mine && dat_in_idx == IDX_W'(g)),
            .st       (st[g]),
            .send_req (sreq_v[g]),
            .send_mem (smem_v[g]),
            .done     (done_v[g])
        );
    end

    msi_bus_req #(.IDX_W(IDX_W)) u_req (
        .clk  (clk),
        .rst  (rst),
        .issue(core_fire && act == ACT_BUS),
        .op   (bus_op_for(cop)),
        .idx  (core_req_idx),
        .grant(bus_req_grant),
        .valid(bus_req_valid),
        .op_q (req_op_q),
        .idx_q(bus_req_idx)
    );

    assign bus_req_op  = req_op_q;
    assign bus_req_src = SELF;

    msi_dat_out #(.ID_W(ID_W), .IDX_W(IDX_W)) u_dout (
        .clk     (clk),
        .rst     (rst),
        .to_req  (|sreq_v),
        .to_mem  (|smem_v),
        .req_id  (snp_src),
        .idx     (snp_idx),
        .valid_q (dat_out_valid),
        .to_req_q(dat_out_to_req),
        .to_mem_q(dat_out_to_mem),
        .req_id_q(dat_out_req_id),
        .idx_q   (dat_out_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) core_done <= 1'b0;
        else     core_done <= |done_v;
    end

endmodule

// File: rtl/msi_chk.sv
module msi_chk #(
    parameter int LINES = 4,
    parameter int ID_W  = 2,
    parameter int MY_ID = 1,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             core_req_valid,
    input logic             core_req_ready,
    input logic             core_done,
    input logic             bus_req_valid,
    input logic [1:0]       bus_req_op,
    input logic [IDX_W-1:0] bus_req_idx,
    input logic             bus_req_grant,
    input logic             snp_valid,
    input logic [ID_W-1:0]  snp_src,
    input logic             dat_in_valid,
    input logic [ID_W-1:0]  dat_in_dst,
    input logic             dat_out_valid,
    input logic             dat_out_to_req,
    input logic             dat_out_to_mem,
    input logic [ID_W-1:0]  dat_out_req_id
);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid && !bus_req_grant |=>
            bus_req_valid && $stable(bus_req_op) && $stable(bus_req_idx));

    // R2
    done_after_data_chk: assert property (@(posedge clk) disable iff (rst)
        core_done |-> $past(dat_in_valid && dat_in_dst == ID_W'(MY_ID)));

    // R6
    dout_after_snoop_chk: assert property (@(posedge clk) disable iff (rst)
        dat_out_valid |-> $past(snp_valid) && dat_out_req_id == $past(snp_src));

    // R8
    dout_has_dest_chk: assert property (@(posedge clk) disable iff (rst)
        dat_out_valid |-> (dat_out_to_req || dat_out_to_mem));

    // R10
    req_from_core_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req_valid) |-> $past(core_req_valid && core_req_ready));

endmodule

bind msi_snoop_ctrl msi_chk #(.LINES(LINES), .ID_W(ID_W), .MY_ID(MY_ID)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .core_req_valid(core_req_valid),
    .core_req_ready(core_req_ready),
    .core_done     (core_done),
    .bus_req_valid (bus_req_valid),
    .bus_req_op    (bus_req_op),
    .bus_req_idx   (bus_req_idx),
    .bus_req_grant (bus_req_grant),
    .snp_valid     (snp_valid),
    .snp_src       (snp_src),
    .dat_in_valid  (dat_in_valid),
    .dat_in_dst    (dat_in_dst),
    .dat_out_valid (dat_out_valid),
    .dat_out_to_req(dat_out_to_req),
    .dat_out_to_mem(dat_out_to_mem),
    .dat_out_req_id(dat_out_req_id)
);

// File: tb/sim_msi_snoop_ctrl.sv
module sim_msi_snoop_ctrl;

    localparam int LD = 0, ST = 1, RP = 2;
    localparam int GETS = 0, GETM = 1, PUTM = 2;
    localparam int ME = 1, PEER = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       core_req_valid = 1'b0;
    logic [1:0] core_req_op = 2'd0;
    logic [1:0] core_req_idx = 2'd0;
    logic       core_req_ready, core_hit, core_done;
    logic       bus_req_valid;
    logic [1:0] bus_req_op;
    logic [1:0] bus_req_src;
    logic [1:0] bus_req_idx;
    logic       bus_req_grant = 1'b0;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_op = 2'd0;
    logic [1:0] snp_src = 2'd0;
    logic [1:0] snp_idx = 2'd0;
    logic       dat_in_valid = 1'b0;
    logic [1:0] dat_in_dst = 2'd0;
    logic [1:0] dat_in_idx = 2'd0;
    logic       dat_out_valid, dat_out_to_req, dat_out_to_mem;
    logic [1:0] dat_out_req_id, dat_out_idx;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    msi_snoop_ctrl #(.LINES(4), .ID_W(2), .MY_ID(ME)) u0 (.*);

    task automatic expect_eq(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic core_go(input int op, input int idx, output bit rdy, output bit hit);
        @(negedge clk);
        core_req_valid = 1'b1; core_req_op = 2'(op); core_req_idx = 2'(idx);
        #1;
        rdy = core_req_ready; hit = core_hit;
        @(posedge clk); #1;
        core_req_valid = 1'b0;
    endtask

    task automatic snoop(input int op, input int src, input int idx);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = 2'(op); snp_src = 2'(src); snp_idx = 2'(idx);
        @(posedge clk); #1;
        snp_valid = 1'b0;
    endtask

    task automatic data_in(input int dst, input int idx);
        @(negedge clk);
        dat_in_valid = 1'b1; dat_in_dst = 2'(dst); dat_in_idx = 2'(idx);
        @(posedge clk); #1;
        dat_in_valid = 1'b0;
    endtask

    task automatic grant(input string tag);
        @(negedge clk);
        bus_req_grant = 1'b1;
        @(posedge clk); #1;
        bus_req_grant = 1'b0;
        expect_eq(tag, "bus_req_valid after grant", int'(bus_req_valid), 0);
    endtask

    task automatic expect_core(input string tag, input int op, input int idx, input int er, input int eh);
        bit r, h;
        core_go(op, idx, r, h);
        expect_eq(tag, "core_req_ready", int'(r), er);
        expect_eq(tag, "core_hit", int'(h), eh);
    endtask

    task automatic expect_busreq(input string tag, input int op, input int idx);
        expect_eq(tag, "bus_req_valid", int'(bus_req_valid), 1);
        expect_eq(tag, "bus_req_op", int'(bus_req_op), op);
        expect_eq(tag, "bus_req_idx", int'(bus_req_idx), idx);
    endtask

    task automatic expect_dout(input string tag, input int v, input int rq, input int mm);
        expect_eq(tag, "dat_out_valid", int'(dat_out_valid), v);
        if (v) begin
            expect_eq(tag, "dat_out_to_req", int'(dat_out_to_req), rq);
            expect_eq(tag, "dat_out_to_mem", int'(dat_out_to_mem), mm);
        end
    endtask

    // complete an already issued and pending miss
    task automatic finish_miss(input string tag, input int bop, input int idx);
        grant(tag);
        snoop(bop, ME, idx);
        data_in(ME, idx);
        expect_eq(tag, "core_done", int'(core_done), 1);
    endtask

    task automatic fill(input string tag, input int op, input int idx);
        expect_core(tag, op, idx, 1, 0);
        expect_busreq(tag, (op == LD) ? GETS : GETM, idx);
        finish_miss(tag, (op == LD) ? GETS : GETM, idx);
    endtask

    task automatic t_reset;
        expect_eq("R1", "bus_req_valid", int'(bus_req_valid), 0);
        expect_eq("R1", "dat_out_valid", int'(dat_out_valid), 0);
        expect_eq("R1", "core_done", int'(core_done), 0);
    endtask

    task automatic t_load_miss;
        expect_core("R1", LD, 0, 1, 0);
        expect_busreq("R2", GETS, 0);
        expect_eq("R12", "bus_req_src", int'(bus_req_src), ME);
        expect_core("R10", LD, 0, 0, 0);
        grant("R2");
        snoop(GETS, ME, 0);
        expect_dout("R2", 0, 0, 0);
        expect_core("R2", LD, 0, 0, 0);
        data_in(ME, 0);
        expect_eq("R2", "core_done", int'(core_done), 1);
        expect_core("R2", LD, 0, 1, 1);
    endtask

    task automatic t_store_miss;
        fill("R3", ST, 1);
        expect_core("R3", ST, 1, 1, 1);
        expect_core("R3", LD, 1, 1, 1);
    endtask

    task automatic t_single;
        bit r, h;
        expect_core("R10", LD, 2, 1, 0);
        expect_busreq("R10", GETS, 2);
        expect_core("R10", ST, 3, 0, 0);
        expect_core("R10", RP, 2, 0, 0);
        // same-index snoop blocks a hit on line 0 (shared)
        @(negedge clk);
        core_req_valid = 1'b1; core_req_op = 2'(LD); core_req_idx = 2'd0;
        snp_valid = 1'b1; snp_op = 2'(GETS); snp_src = 2'(PEER); snp_idx = 2'd0;
        #1; r = core_req_ready; h = core_hit;
        @(posedge clk); #1;
        core_req_valid = 1'b0; snp_valid = 1'b0;
        expect_eq("R10", "ready under same-index snoop", int'(r), 0);
        expect_eq("R10", "hit under same-index snoop", int'(h), 0);
        finish_miss("R10", GETS, 2);
    endtask

    task automatic t_upgrade;
        expect_core("R4", ST, 2, 1, 0);
        expect_busreq("R4", GETM, 2);
        expect_core("R4", LD, 2, 1, 1);
        grant("R4");
        snoop(GETM, ME, 2);
        expect_core("R4", LD, 2, 1, 1);
        expect_core("R4", ST, 2, 0, 0);
        data_in(ME, 2);
        expect_eq("R4", "core_done", int'(core_done), 1);
        expect_core("R4", ST, 2, 1, 1);
    endtask

    task automatic t_race;
        expect_core("R5", ST, 0, 1, 0);
        expect_busreq("R5", GETM, 0);
        grant("R5");
        snoop(GETM, PEER, 0);
        expect_dout("R5", 0, 0, 0);
        expect_core("R5", LD, 0, 0, 0);
        snoop(GETM, ME, 0);
        data_in(ME, 0);
        expect_eq("R5", "core_done", int'(core_done), 1);
        expect_core("R5", ST, 0, 1, 1);
    endtask

    task automatic t_m_snoop;
        snoop(GETS, PEER, 1);
        expect_dout("R6", 1, 1, 1);
        expect_eq("R6", "dat_out_req_id", int'(dat_out_req_id), PEER);
        expect_eq("R6", "dat_out_idx", int'(dat_out_idx), 1);
        expect_core("R6", ST, 1, 1, 0);
        expect_busreq("R6", GETM, 1);
        finish_miss("R6", GETM, 1);
        snoop(GETM, PEER, 1);
        expect_dout("R6", 1, 1, 0);
        expect_core("R6", LD, 1, 1, 0);
        expect_busreq("R6", GETS, 1);
        finish_miss("R6", GETS, 1);
    endtask

    task automatic t_s_inval;
        snoop(GETM, PEER, 1);
        expect_dout("R7", 0, 0, 0);
        expect_core("R7", LD, 1, 1, 0);
        expect_busreq("R7", GETS, 1);
        finish_miss("R7", GETS, 1);
    endtask

    task automatic t_replace;
        expect_core("R8", RP, 1, 1, 0);
        expect_eq("R8", "no PutM for shared", int'(bus_req_valid), 0);
        expect_core("R8", LD, 1, 1, 0);
        expect_busreq("R8", GETS, 1);
        finish_miss("R8", GETS, 1);
        expect_core("R8", RP, 0, 1, 0);
        expect_busreq("R8", PUTM, 0);
        expect_core("R8", LD, 0, 1, 1);
        expect_core("R8", ST, 0, 1, 1);
        expect_core("R8", RP, 0, 0, 0);
        grant("R8");
        snoop(PUTM, ME, 0);
        expect_dout("R8", 1, 0, 1);
        expect_core("R8", LD, 0, 1, 0);
        expect_busreq("R8", GETS, 0);
        finish_miss("R8", GETS, 0);
    endtask

    task automatic t_iia;
        expect_core("R9", RP, 2, 1, 0);
        expect_busreq("R9", PUTM, 2);
        grant("R9");
        snoop(GETM, PEER, 2);
        expect_dout("R9", 1, 1, 0);
        expect_core("R9", LD, 2, 0, 0);
        snoop(PUTM, ME, 2);
        expect_dout("R9", 0, 0, 0);
        expect_core("R9", LD, 2, 1, 0);
        expect_busreq("R9", GETS, 2);
        finish_miss("R9", GETS, 2);
        fill("R9", ST, 3);
        expect_core("R9", RP, 3, 1, 0);
        expect_busreq("R9", PUTM, 3);
        snoop(GETS, PEER, 3);
        expect_dout("R9", 1, 1, 1);
        expect_core("R9", ST, 3, 0, 0);
        grant("R9");
        snoop(PUTM, ME, 3);
        expect_dout("R9", 0, 0, 0);
    endtask

    task automatic t_ignore;
        snoop(GETS, PEER, 3);
        expect_dout("R11", 0, 0, 0);
        snoop(GETM, PEER, 3);
        expect_dout("R11", 0, 0, 0);
        snoop(PUTM, PEER, 3);
        expect_dout("R11", 0, 0, 0);
        expect_core("R11", LD, 3, 1, 0);
        expect_busreq("R11", GETS, 3);
        repeat (2) @(posedge clk);
        #1;
        expect_busreq("R12", GETS, 3);
        grant("R12");
        snoop(GETS, ME, 3);
        data_in(PEER, 3);
        expect_eq("R11", "core_done for foreign data", int'(core_done), 0);
        expect_core("R11", LD, 3, 0, 0);
        data_in(ME, 3);
        expect_eq("R11", "core_done", int'(core_done), 1);
        expect_core("R11", LD, 3, 1, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset;
        t_load_miss;
        t_store_miss;
        t_single;
        t_upgrade;
        t_race;
        t_m_snoop;
        t_s_inval;
        t_replace;
        t_iia;
        t_ignore;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule